// File: doc/BRIEF.md
# Alert Classifier and Interrupt Aggregator

This block sorts incoming alert events into four classes. It takes `NUM_ALERTS` external alert strobes and four internal failure strobes. Each source passes through its own enable. An enabled event then lands in one of four classes, according to a 2-bit class selector held per source. Every accepted event sets a sticky cause bit for its source and a sticky interrupt bit for its class. Software clears both kinds of bit by writing one. For each class the block also gives a one-cycle pulse and a count of the sources that fired in that cycle, so that escalation logic further on can follow the traffic.

The four internal sources sit at fixed positions. Position 0 is a ping failure seen by an alert receiver, 1 is a ping failure seen by an escalation sender, 2 is an integrity failure seen by an alert receiver, and 3 is an integrity failure seen by an escalation sender. They share the configuration path with the external sources at source indices `NUM_ALERTS` to `NUM_ALERTS+3`.

Configuration is written one source per strobe. A global configuration-open flag starts at 1 and can only be cleared. Once it is cleared, the enable and class settings are frozen until reset. Events and clear strobes are plain level inputs, sampled on each rising edge. The block accepts every event in every cycle, so it has no ready signal and applies no back-pressure. A source that fires must hold its strobe for exactly the cycles in which it means to raise an event.

Top module: `alert_classifier`

## Requirements
- R1: Each source has an enable bit and a 2-bit class selector, where 0, 1, 2 and 3 select class A, B, C and D (bit 0 to bit 3 of the per-class outputs). An enabled event routes to the selected class, and the result appears on the outputs one cycle after the event is sampled.
- R2: An event on a disabled source sets no cause bit and adds nothing to any class pulse, count or interrupt.
- R3: The cause bit of a source (`cause_o[s]`, with external alert k at s=k and local source k at s=NUM_ALERTS+k) is set one cycle after an enabled event. It stays set until a cycle in which `cause_clr_i[s]` is 1.
- R4: `irq_o[c]` is set one cycle after any enabled event of class c. It stays set until `irq_clr_i[c]` is 1, and it clears one cycle after that strobe.
- R5: When a hardware set and a software clear hit the same cause bit or the same interrupt bit in one cycle, the bit ends up set.
- R6: The local strobes `local_evt_i[0..3]` (receiver ping failure, sender ping failure, receiver integrity failure, sender integrity failure) are configured at source indices NUM_ALERTS+0 to NUM_ALERTS+3. Each has its own enable and class.
- R7: `class_pulse_o[c]` is high for exactly one cycle for each cycle in which one or more enabled events of class c were sampled. `class_cnt_o[c*CNTW +: CNTW]` gives the number of those events.
- R8: `cfg_open_o` is 1 after reset, drops to 0 one cycle after `lock_clr_i`, and stays 0 until reset.
- R9: While `cfg_open_o` is 0, configuration writes have no effect. A write in the same cycle as `lock_clr_i` is still accepted.
- R10: A configuration write whose `cfg_idx_i` is NUM_ALERTS+4 or above changes no source.
- R11: After reset, every source is disabled with class A, and all cause bits, interrupt bits, pulses and counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alert_evt_i | input | NUM_ALERTS | External alert event strobes |
| local_evt_i | input | 4 | Local failure event strobes |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDXW | Source index of the write |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_class_i | input | 2 | Class selector to write |
| lock_clr_i | input | 1 | Write-one to clear the configuration-open flag |
| cfg_open_o | output | 1 | Configuration-open flag |
| cause_clr_i | input | NSRC | Write-one-to-clear strobes for cause bits |
| cause_o | output | NSRC | Sticky cause bits |
| irq_clr_i | input | 4 | Write-one-to-clear strobes for class interrupts |
| irq_o | output | 4 | Class interrupt state bits |
| class_pulse_o | output | 4 | One-cycle class alert pulses |
| class_cnt_o | output | 4*CNTW | Per-class count of events in the pulse cycle |

## Verification
All results are registered. A cause bit, an interrupt bit, a class pulse and its count all change on the first rising edge that samples the event, so they are due one cycle after the stimulus. A configuration write or a lock strobe changes behaviour from the next sampled cycle. The bench drives inputs just after each falling edge and updates its model at each rising edge from those inputs, using the configuration from before that edge. It compares every output at the next falling edge. As a result, each prediction is checked in exactly the cycle in which the requirement says the result appears.

// File: rtl/alert_cls_pkg.sv
package alert_cls_pkg;

  localparam int unsigned NUM_CLASSES = 4;
  localparam int unsigned NUM_LOCAL   = 4;
  localparam int unsigned CLS_W       = 2;

  typedef logic [CLS_W-1:0] cls_sel_t;

  // fixed positions of the local failure sources inside local_evt_i
  typedef enum logic [1:0] {
    LOC_RX_PING  = 2'd0,
    LOC_TX_PING  = 2'd1,
    LOC_RX_INTEG = 2'd2,
    LOC_TX_INTEG = 2'd3
  } local_src_e;

  typedef struct packed {
    logic     en;
    cls_sel_t cls;
  } src_cfg_t;

endpackage

// File: rtl/alert_cfg_store.sv
module alert_cfg_store
  import alert_cls_pkg::*;
#(
  parameter int unsigned NSRC = 12,
  parameter int unsigned IDXW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [IDXW-1:0]      idx_i,
  input  logic                 en_i,
  input  cls_sel_t             cls_i,
  input  logic                 lock_clr_i,
  output src_cfg_t [NSRC-1:0]  cfg_o,
  output logic                 open_o
);

  localparam logic [IDXW:0] IDX_LIMIT = (IDXW+1)'(NSRC);

  logic     open_q;
  logic     wr_ok;
  src_cfg_t wr_val;

  // the flag can only fall; it returns to 1 on reset alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b1;
    end else if (lock_clr_i) begin
      open_q <= 1'b0;
    end
  end

  // writes are gated by the flag value before this edge
  assign wr_ok  = wr_i & open_q & ({1'b0, idx_i} < IDX_LIMIT);
  assign wr_val = '{en: en_i, cls: cls_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[s] <= '0;
      end else if (wr_ok && (idx_i == IDXW'(s))) begin
        cfg_o[s] <= wr_val;
      end
    end
  end

  assign open_o = open_q;

endmodule

// File: rtl/alert_gate_route.sv
module alert_gate_route
  import alert_cls_pkg::*;
#(
  parameter int unsigned NSRC = 12
) (
  input  logic [NSRC-1:0]                   evt_i,
  input  src_cfg_t [NSRC-1:0]               cfg_i,
  output logic [NSRC-1:0]                   hit_o,
  output logic [NUM_CLASSES-1:0][NSRC-1:0]  cls_hit_o
);

  for (genvar s = 0; s < NSRC; s++) begin : g_gate
    assign hit_o[s] = evt_i[s] & cfg_i[s].en;
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign cls_hit_o[c][s] = hit_o[s] & (cfg_i[s].cls == CLS_W'(c));
    end
  end

endmodule

// File: rtl/alert_sticky_bank.sv
module alert_sticky_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  // set takes priority over a same-cycle write-one clear
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o[b] <= 1'b0;
      end else if (set_i[b]) begin
        q_o[b] <= 1'b1;
      end else if (clr_i[b]) begin
        q_o[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/alert_class_count.sv
module alert_class_count
  import alert_cls_pkg::*;
#(
  parameter int unsigned NSRC = 12,
  parameter int unsigned CNTW = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_CLASSES-1:0][NSRC-1:0]      cls_hit_i,
  output logic [NUM_CLASSES-1:0]                pulse_o,
  output logic [NUM_CLASSES-1:0][CNTW-1:0]      cnt_o
);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [CNTW-1:0] sum;

    always_comb begin
      sum = '0;
      for (int s = 0; s < NSRC; s++) begin
        sum = sum + CNTW'(cls_hit_i[c][s]);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pulse_o[c] <= 1'b0;
        cnt_o[c]   <= '0;
      end else begin
        pulse_o[c] <= |cls_hit_i[c];
        cnt_o[c]   <= sum;
      end
    end
  end

endmodule

// File: rtl/alert_classifier.sv
module alert_classifier
  import alert_cls_pkg::*;
#(
  parameter  int unsigned NUM_ALERTS = 8,
  localparam int unsigned NSRC       = NUM_ALERTS + NUM_LOCAL,
  localparam int unsigned IDXW       = $clog2(NSRC),
  localparam int unsigned CNTW       = $clog2(NSRC + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_ALERTS-1:0]       alert_evt_i,
  input  logic [NUM_LOCAL-1:0]        local_evt_i,
  input  logic                        cfg_wr_i,
  input  logic [IDXW-1:0]             cfg_idx_i,
  input  logic                        cfg_en_i,
  input  logic [CLS_W-1:0]            cfg_class_i,
  input  logic                        lock_clr_i,
  output logic                        cfg_open_o,
  input  logic [NSRC-1:0]             cause_clr_i,
  output logic [NSRC-1:0]             cause_o,
  input  logic [NUM_CLASSES-1:0]      irq_clr_i,
  output logic [NUM_CLASSES-1:0]      irq_o,
  output logic [NUM_CLASSES-1:0]      class_pulse_o,
  output logic [NUM_CLASSES*CNTW-1:0] class_cnt_o
);

  src_cfg_t [NSRC-1:0]                 cfg;
  logic [NSRC-1:0]                     evt_all;
  logic [NSRC-1:0]                     hit;
  logic [NUM_CLASSES-1:0][NSRC-1:0]    cls_hit;
  logic [NUM_CLASSES-1:0]              cls_any;
  logic [NUM_CLASSES-1:0][CNTW-1:0]    cnt;

  // local sources follow the external ones in the source index space
  assign evt_all = {local_evt_i, alert_evt_i};

  alert_cfg_store #(
    .NSRC (NSRC),
    .IDXW (IDXW)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i),
    .idx_i      (cfg_idx_i),
    .en_i       (cfg_en_i),
    .cls_i      (cfg_class_i),
    .lock_clr_i (lock_clr_i),
    .cfg_o      (cfg),
    .open_o     (cfg_open_o)
  );

  alert_gate_route #(
    .NSRC (NSRC)
  ) u_route (
    .evt_i     (evt_all),
    .cfg_i     (cfg),
    .hit_o     (hit),
    .cls_hit_o (cls_hit)
  );

  alert_sticky_bank #(
    .W (NSRC)
  ) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (cause_clr_i),
    .q_o    (cause_o)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_any
    assign cls_any[c] = |cls_hit[c];
  end

  alert_sticky_bank #(
    .W (NUM_CLASSES)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cls_any),
    .clr_i  (irq_clr_i),
    .q_o    (irq_o)
  );

  alert_class_count #(
    .NSRC (NSRC),
    .CNTW (CNTW)
  ) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cls_hit_i (cls_hit),
    .pulse_o   (class_pulse_o),
    .cnt_o     (cnt)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_flat
    assign class_cnt_o[c*CNTW +: CNTW] = cnt[c];
  end

endmodule

// File: rtl/alert_classifier_chk.sv
module alert_classifier_chk
  import alert_cls_pkg::*;
#(
  parameter  int unsigned NUM_ALERTS = 8,
  localparam int unsigned NSRC       = NUM_ALERTS + NUM_LOCAL,
  localparam int unsigned IDXW       = $clog2(NSRC),
  localparam int unsigned CNTW       = $clog2(NSRC + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_ALERTS-1:0]       alert_evt_i,
  input logic [NUM_LOCAL-1:0]        local_evt_i,
  input logic                        cfg_wr_i,
  input logic [IDXW-1:0]             cfg_idx_i,
  input logic                        cfg_en_i,
  input logic [CLS_W-1:0]            cfg_class_i,
  input logic                        lock_clr_i,
  input logic                        cfg_open_o,
  input logic [NSRC-1:0]             cause_clr_i,
  input logic [NSRC-1:0]             cause_o,
  input logic [NUM_CLASSES-1:0]      irq_clr_i,
  input logic [NUM_CLASSES-1:0]      irq_o,
  input logic [NUM_CLASSES-1:0]      class_pulse_o,
  input logic [NUM_CLASSES*CNTW-1:0] class_cnt_o
);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |=> !cfg_open_o); // R8

  AST_CAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_o & $past(cause_o & ~cause_clr_i)) == $past(cause_o & ~cause_clr_i))); // R3

  AST_CAUSE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cause_o & ~$past(cause_o))) |-> $past(|{local_evt_i, alert_evt_i})); // R2

  AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|class_pulse_o) |-> $past(|{local_evt_i, alert_evt_i})); // R7

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    AST_PULSE_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      class_pulse_o[c] |-> irq_o[c]); // R5

    AST_CNT_MATCHES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (class_cnt_o[c*CNTW +: CNTW] != '0) == class_pulse_o[c]); // R7

    AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(irq_clr_i[c]) && !class_pulse_o[c]) |-> !irq_o[c]); // R4
  end

endmodule

bind alert_classifier alert_classifier_chk #(.NUM_ALERTS(NUM_ALERTS)) u_chk (.*);

// File: tb/alert_classifier_test.sv
`timescale 1ns/1ps
module alert_classifier_test;

  localparam int NA   = 8;
  localparam int NSRC = NA + 4;
  localparam int IDXW = $clog2(NSRC);
  localparam int CNTW = $clog2(NSRC + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NA-1:0]        alert_evt = '0;
  logic [3:0]           local_evt = '0;
  logic                 cfg_wr = 1'b0;
  logic [IDXW-1:0]      cfg_idx = '0;
  logic                 cfg_en = 1'b0;
  logic [1:0]           cfg_class = '0;
  logic                 lock_clr = 1'b0;
  logic                 cfg_open;
  logic [NSRC-1:0]      cause_clr = '0;
  logic [NSRC-1:0]      cause;
  logic [3:0]           irq_clr = '0;
  logic [3:0]           irq;
  logic [3:0]           pulse;
  logic [4*CNTW-1:0]    cnt;

  alert_classifier #(.NUM_ALERTS(NA)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .alert_evt_i  (alert_evt),
    .local_evt_i  (local_evt),
    .cfg_wr_i     (cfg_wr),
    .cfg_idx_i    (cfg_idx),
    .cfg_en_i     (cfg_en),
    .cfg_class_i  (cfg_class),
    .lock_clr_i   (lock_clr),
    .cfg_open_o   (cfg_open),
    .cause_clr_i  (cause_clr),
    .cause_o      (cause),
    .irq_clr_i    (irq_clr),
    .irq_o        (irq),
    .class_pulse_o(pulse),
    .class_cnt_o  (cnt)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  string phase = "R11";

  // behavioural reference model
  bit              m_en   [NSRC];
  int              m_cls  [NSRC];
  bit              m_open;
  bit [NSRC-1:0]   m_cause;
  bit [3:0]        m_irq;
  bit [3:0]        m_pulse;
  int              m_cnt  [4];
  logic [NSRC-1:0] ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_en[s]) begin m_en[s] = 1'b0; m_cls[s] = 0; end
      m_open = 1'b1; m_cause = '0; m_irq = '0; m_pulse = '0;
      foreach (m_cnt[c]) m_cnt[c] = 0;
    end else begin
      ev = {local_evt, alert_evt};
      foreach (m_cnt[c]) m_cnt[c] = 0;
      m_cause = m_cause & ~cause_clr;
      m_irq   = m_irq & ~irq_clr;
      for (int s = 0; s < NSRC; s++) begin
        if (ev[s] && m_en[s]) begin
          m_cause[s] = 1'b1;
          m_cnt[m_cls[s]]++;
        end
      end
      for (int c = 0; c < 4; c++) begin
        m_pulse[c] = (m_cnt[c] != 0);
        if (m_pulse[c]) m_irq[c] = 1'b1;
      end
      if (cfg_wr && m_open && (int'(cfg_idx) < NSRC)) begin
        m_en[cfg_idx]  = cfg_en;
        m_cls[cfg_idx] = int'(cfg_class);
      end
      if (lock_clr) m_open = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4*CNTW-1:0] exp_cnt();
    logic [4*CNTW-1:0] v;
    for (int c = 0; c < 4; c++) v[c*CNTW +: CNTW] = CNTW'(m_cnt[c]);
    return v;
  endfunction

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cause == m_cause, {"R3/", phase}, "cause", 32'(cause), 32'(m_cause));
      chk(irq == m_irq, {"R4/", phase}, "irq", 32'(irq), 32'(m_irq));
      chk(pulse == m_pulse, {"R7/", phase}, "pulse", 32'(pulse), 32'(m_pulse));
      chk(cnt == exp_cnt(), {"R7/", phase}, "count", 32'(cnt), 32'(exp_cnt()));
      chk(cfg_open == m_open, {"R8/", phase}, "open", 32'(cfg_open), 32'(m_open));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic quiet();
    alert_evt = '0; local_evt = '0; cfg_wr = 1'b0; lock_clr = 1'b0;
    cause_clr = '0; irq_clr = '0;
  endtask

  task automatic wr_cfg(input int idx, input bit en, input int cls);
    quiet();
    cfg_wr = 1'b1; cfg_idx = IDXW'(idx); cfg_en = en; cfg_class = 2'(cls);
    tick();
    quiet();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R11: reset state
    chk(cause == '0 && irq == '0 && pulse == '0 && cnt == '0, "R11", "reset outputs",
        {cause, irq, pulse}, 32'd0);
    chk(cfg_open == 1'b1, "R11", "reset open", 32'(cfg_open), 32'd1);
    // R11/R2: every source disabled after reset
    phase = "R2";
    alert_evt = '1; local_evt = '1; tick(); quiet();
    chk(cause == '0 && pulse == '0, "R2", "disabled after reset", 32'(cause), 32'd0);

    // random activity with configuration while open
    phase = "rand_open";
    for (int i = 0; i < 80; i++) begin
      alert_evt = NA'($urandom); local_evt = 4'($urandom);
      cause_clr = NSRC'($urandom); irq_clr = 4'($urandom);
      cfg_wr = 1'($urandom); cfg_idx = IDXW'($urandom_range(0, NSRC + 2));
      cfg_en = 1'($urandom); cfg_class = 2'($urandom);
      tick();
    end
    quiet();

    // deterministic routing: alert s -> class s%4, local k -> class 3-k
    phase = "R1";
    for (int s = 0; s < NA; s++) wr_cfg(s, 1'b1, s % 4);
    for (int k = 0; k < 4; k++) wr_cfg(NA + k, 1'b1, 3 - k);
    cause_clr = '1; irq_clr = '1; tick(); quiet(); tick();
    alert_evt[5] = 1'b1; tick(); quiet();
    chk(pulse == 4'b0010, "R1", "alert5 to class B", 32'(pulse), 32'h2);
    chk(cause == NSRC'(1 << 5), "R1", "alert5 cause", 32'(cause), 32'h20);

    phase = "R6";
    local_evt[2] = 1'b1; tick(); quiet();
    chk(pulse == 4'b0010, "R6", "rx integ to class B", 32'(pulse), 32'h2);
    chk(cause[NA+2] == 1'b1, "R6", "rx integ cause", 32'(cause), 32'(1 << (NA + 2)));
    local_evt[0] = 1'b1; tick(); quiet();
    chk(pulse == 4'b1000, "R6", "rx ping to class D", 32'(pulse), 32'h8);

    phase = "R7";
    alert_evt[0] = 1'b1; alert_evt[4] = 1'b1; alert_evt[1] = 1'b1; tick(); quiet();
    chk(cnt[0 +: CNTW] == CNTW'(2), "R7", "class A count", 32'(cnt[0 +: CNTW]), 32'd2);
    chk(cnt[CNTW +: CNTW] == CNTW'(1), "R7", "class B count", 32'(cnt[CNTW +: CNTW]), 32'd1);
    tick();
    chk(pulse == 4'b0000, "R7", "pulse lasts one cycle", 32'(pulse), 32'd0);

    phase = "R3";
    cause_clr = '1; tick(); quiet();
    chk(cause == '0, "R3", "cause cleared", 32'(cause), 32'd0);

    phase = "R5";
    alert_evt[2] = 1'b1; cause_clr[2] = 1'b1; irq_clr[2] = 1'b1; tick(); quiet();
    chk(cause[2] == 1'b1, "R5", "cause set wins", 32'(cause), 32'h4);
    chk(irq[2] == 1'b1, "R5", "irq set wins", 32'(irq), 32'h4);

    phase = "R4";
    irq_clr = '1; tick(); quiet();
    chk(irq == 4'b0000, "R4", "irq cleared", 32'(irq), 32'd0);

    phase = "R2";
    wr_cfg(3, 1'b0, 3);
    cause_clr = '1; tick(); quiet();
    alert_evt[3] = 1'b1; tick(); quiet();
    chk(cause[3] == 1'b0 && pulse == '0, "R2", "disabled alert3", 32'(cause), 32'd0);

    phase = "R10";
    wr_cfg(NSRC + 1, 1'b0, 0);
    alert_evt = '1; alert_evt[3] = 1'b0; local_evt = '1; tick(); quiet();
    chk(&cause[NSRC-1:4] && &cause[2:0], "R10", "out-of-range write", 32'(cause), 32'hff7);

    phase = "R9";
    cfg_wr = 1'b1; cfg_idx = IDXW'(3); cfg_en = 1'b1; cfg_class = 2'd2; lock_clr = 1'b1;
    tick(); quiet();
    chk(cfg_open == 1'b0, "R8", "lock clears open", 32'(cfg_open), 32'd0);
    wr_cfg(0, 1'b1, 3);
    alert_evt[3] = 1'b1; alert_evt[0] = 1'b1; tick(); quiet();
    chk(pulse == 4'b0101, "R9", "locked write ignored, same-cycle write kept",
        32'(pulse), 32'h5);

    phase = "rand_locked";
    for (int i = 0; i < 120; i++) begin
      alert_evt = NA'($urandom); local_evt = 4'($urandom);
      cause_clr = NSRC'($urandom); irq_clr = 4'($urandom);
      cfg_wr = 1'($urandom); cfg_idx = IDXW'($urandom);
      cfg_en = 1'($urandom); cfg_class = 2'($urandom);
      lock_clr = 1'($urandom);
      tick();
    end
    quiet(); tick();
    chk(cfg_open == 1'b0, "R8", "open stays low", 32'(cfg_open), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule